// File: doc/BRIEF.md
# Three-Stream LZ Decompressor

This engine expands a block of LZ-packed data held in a byte-addressed memory. The packed block starts with a 16-byte header. Three fields in that header give the unpacked size, the location of a stream of 16-bit copy codes, and the location of a byte stream. The byte stream carries both literal bytes and the extra length bytes of long copies. A third stream of 32-bit control words sits right after the header. Each control bit picks one of two actions: emit one literal byte, or copy a run of bytes that were already written.

Software, or a neighbouring controller, places the packed block at `src_base` and pulses `start` with a destination address. The engine then reads the header and the three streams through a single byte read port with one cycle of latency. It writes the unpacked bytes through a byte write port. Copy sources are read back from the same memory, one byte at a time. The engine signals the end with a one-cycle `done` pulse. If a copy code points in front of the destination area, `err` is raised and decoding stops.

Top module: `lz3_unpacker`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `busy`, `done`, `err`, `rd_en` and `wr_en` are all 0.
- R2: When `start` is sampled high while `busy` is 0, both base addresses are latched and `busy` is 1 on the next cycle. A `start` pulse while `busy` is 1 is ignored and does not change the data written.
- R3: The header is read as big-endian 32-bit words: the unpacked length at `src_base`+4, the code stream offset at +8 and the byte stream offset at +12. Both offsets are relative to `src_base`. The control words are read big-endian from `src_base`+16 onward.
- R4: Control bits are used starting from bit 31 of each word. A new control word is read only after all 32 bits of the previous one have been used, so a block of more than 32 items reads consecutive words.
- R5: A control bit of 1 takes the next byte of the byte stream and writes it at the current output address. The output address then advances by one.
- R6: A control bit of 0 takes the next big-endian 16-bit copy code. Bits 15..12 form a length field L, and bits 11..0 form a distance D. The copy source is the output address minus D minus 1. When L is not 0, the copy is L+2 bytes long.
- R7: When L is 0, the next byte of the byte stream (the same pointer used for literals) is read as N, and the copy is N+18 bytes long.
- R8: A copy moves one byte at a time and each read follows the previous write. A source that overlaps the bytes being written (small D) therefore repeats the most recent output.
- R9: Before each item, decoding ends if the output address has reached `dst_base` plus the unpacked length. A length of 0 writes nothing. The end is marked by a single-cycle `done` pulse, and `busy` falls on the cycle after it.
- R10: A copy code whose source lies below `dst_base` sets `err` and ends the decode with `done`. No byte of that copy is written, and `err` stays set until the next accepted `start`.
- R11: No cycle has both `rd_en` and `wr_en` high, and every write address is at or above `dst_base`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a decode (accepted only while idle) |
| src_base | input | ADDR_W | Address of the packed block header |
| dst_base | input | ADDR_W | First address of the unpacked output |
| busy | output | 1 | Decode in progress |
| done | output | 1 | One-cycle pulse at the end of a decode |
| err | output | 1 | Copy source fell below `dst_base`; held until next start |
| rd_en | output | 1 | Memory read request |
| rd_addr | output | ADDR_W | Memory read byte address |
| rd_data | input | 8 | Read data, valid the cycle after `rd_en` |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | ADDR_W | Memory write byte address |
| wr_data | output | 8 | Memory write data |

## Verification
The assertions assume that the memory returns read data exactly one cycle after `rd_en`. They also assume that the memory does not overlap the packed block with the output region, so copy reads always see bytes the engine itself wrote earlier. The bench keeps both conditions: its memory model is a one-cycle registered array, and it places packed data in the lower half and output in the upper half. Its generated streams only produce copy distances that stay inside the bytes already produced, except in the one case built to trigger the error. The sweep also bounds the total output so it fits the output half of the memory.

// File: rtl/lz3_pkg.sv
package lz3_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_HDR,
      ST_TOKEN,
      ST_FLAGS,
      ST_LIT,
      ST_LITW,
      ST_CODE,
      ST_EXT,
      ST_CRD,
      ST_CWR,
      ST_FIN
   } lz3_state_e;

   localparam int HDR_BYTES   = 16;
   localparam int SHORT_BIAS  = 2;
   localparam int LONG_BIAS   = 18;
   localparam int RUN_W       = 9;

endpackage

// File: rtl/lz3_fetch.sv
module lz3_fetch #(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [2:0]        req_nbytes,
   output logic              rd_en,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [7:0]        rd_data,
   output logic              ack,
   output logic              active,
   output logic [31:0]       value
);

   logic              pend;
   logic [ADDR_W-1:0] ptr;
   logic [2:0]        left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         pend   <= 1'b0;
         ptr    <= '0;
         left   <= '0;
         value  <= '0;
         ack    <= 1'b0;
      end else begin
         ack <= 1'b0;
         if (!active) begin
            if (req) begin
               active <= 1'b1;
               pend   <= 1'b0;
               ptr    <= req_addr;
               left   <= req_nbytes;
               value  <= '0;
            end
         end else if (!pend) begin
            pend <= 1'b1;
            ptr  <= ptr + 1'b1;
         end else begin
            pend  <= 1'b0;
            value <= {value[23:0], rd_data};
            left  <= left - 1'b1;
            if (left == 3'd1) begin
               active <= 1'b0;
               ack    <= 1'b1;
            end
         end
      end
   end

   assign rd_en   = active && !pend;
   assign rd_addr = ptr;

   AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !ack); // R3

   AST_NO_REQ_WHILE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> !req); // R3

endmodule

// File: rtl/lz3_flags.sv
module lz3_flags #(
   parameter int FW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          load,
   input  logic [FW-1:0] word,
   input  logic          take,
   output logic          top_bit,
   output logic          empty
);

   localparam int CNT_W = $clog2(FW + 1);

   logic [FW-1:0]    sreg;
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg <= '0;
         cnt  <= '0;
      end else if (clr) begin
         sreg <= '0;
         cnt  <= '0;
      end else if (load) begin
         sreg <= word;
         cnt  <= CNT_W'(FW);
      end else if (take) begin
         sreg <= {sreg[FW-2:0], 1'b0};
         cnt  <= cnt - 1'b1;
      end
   end

   assign top_bit = sreg[FW-1];
   assign empty   = (cnt == '0);

   AST_TAKE_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> !empty); // R4

   AST_LOAD_ONLY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> (empty && !take)); // R4

endmodule

// File: rtl/lz3_unpacker.sv
module lz3_unpacker
   import lz3_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int FLAG_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] src_base,
   input  logic [ADDR_W-1:0] dst_base,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic              rd_en,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [7:0]        rd_data,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [7:0]        wr_data
);

   localparam int FLAG_BYTES = FLAG_W / 8;

   initial begin
      assert (ADDR_W >= 12 && ADDR_W <= 32)
         else $error("lz3_unpacker: ADDR_W must lie in 12..32");
      assert (FLAG_W == 8 || FLAG_W == 16 || FLAG_W == 32)
         else $error("lz3_unpacker: FLAG_W must be 8, 16 or 32");
   end

   lz3_state_e        state;
   logic [ADDR_W-1:0] src_q, dst_q, end_q;
   logic [ADDR_W-1:0] flag_ptr, code_ptr, byte_ptr, out_ptr, copy_src;
   logic [RUN_W-1:0]  copy_left;
   logic [1:0]        hdr_idx;
   logic [7:0]        hold;
   logic              err_q;

   logic              f_want, f_req, f_ack, f_active;
   logic [ADDR_W-1:0] f_addr;
   logic [2:0]        f_n;
   logic [31:0]       f_value;

   logic              fl_clr, fl_load, fl_take, fl_bit, fl_empty;

   logic [3:0]        code_len;
   logic [11:0]       code_dist;
   logic [ADDR_W:0]   need_back, have_back;
   logic              src_bad;

   always_comb begin
      f_want = 1'b0;
      f_addr = byte_ptr;
      f_n    = 3'd1;
      unique case (state)
         ST_HDR: begin
            f_want = 1'b1;
            f_addr = src_q + ADDR_W'(4) + ADDR_W'({hdr_idx, 2'b00});
            f_n    = 3'd4;
         end
         ST_FLAGS: begin
            f_want = 1'b1;
            f_addr = flag_ptr;
            f_n    = 3'(FLAG_BYTES);
         end
         ST_LIT, ST_EXT: begin
            f_want = 1'b1;
            f_addr = byte_ptr;
         end
         ST_CODE: begin
            f_want = 1'b1;
            f_addr = code_ptr;
            f_n    = 3'd2;
         end
         ST_CRD: begin
            f_want = 1'b1;
            f_addr = copy_src;
         end
         default: ;
      endcase
   end

   assign f_req = f_want && !f_active && !f_ack;

   lz3_fetch #(.ADDR_W(ADDR_W)) u_fetch (
      .clk        (clk),
      .rst_n      (rst_n),
      .req        (f_req),
      .req_addr   (f_addr),
      .req_nbytes (f_n),
      .rd_en      (rd_en),
      .rd_addr    (rd_addr),
      .rd_data    (rd_data),
      .ack        (f_ack),
      .active     (f_active),
      .value      (f_value)
   );

   assign fl_clr  = (state == ST_IDLE) && start;
   assign fl_load = (state == ST_FLAGS) && f_ack;
   assign fl_take = (state == ST_TOKEN) && (out_ptr < end_q) && !fl_empty;

   lz3_flags #(.FW(FLAG_W)) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (fl_clr),
      .load    (fl_load),
      .word    (f_value[FLAG_W-1:0]),
      .take    (fl_take),
      .top_bit (fl_bit),
      .empty   (fl_empty)
   );

   assign code_len  = f_value[15:12];
   assign code_dist = f_value[11:0];
   assign need_back = {1'b0, ADDR_W'(code_dist)} + 1'b1;
   assign have_back = {1'b0, out_ptr - dst_q};
   assign src_bad   = need_back > have_back;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         src_q     <= '0;
         dst_q     <= '0;
         end_q     <= '0;
         flag_ptr  <= '0;
         code_ptr  <= '0;
         byte_ptr  <= '0;
         out_ptr   <= '0;
         copy_src  <= '0;
         copy_left <= '0;
         hdr_idx   <= '0;
         hold      <= '0;
         err_q     <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: if (start) begin
               src_q    <= src_base;
               dst_q    <= dst_base;
               out_ptr  <= dst_base;
               flag_ptr <= src_base + ADDR_W'(HDR_BYTES);
               hdr_idx  <= '0;
               err_q    <= 1'b0;
               state    <= ST_HDR;
            end
            ST_HDR: if (f_ack) begin
               hdr_idx <= hdr_idx + 1'b1;
               unique case (hdr_idx)
                  2'd0:    end_q    <= dst_q + f_value[ADDR_W-1:0];
                  2'd1:    code_ptr <= src_q + f_value[ADDR_W-1:0];
                  default: byte_ptr <= src_q + f_value[ADDR_W-1:0];
               endcase
               if (hdr_idx == 2'd2) state <= ST_TOKEN;
            end
            ST_TOKEN: begin
               if (out_ptr >= end_q) state <= ST_FIN;
               else if (fl_empty)    state <= ST_FLAGS;
               else if (fl_bit)      state <= ST_LIT;
               else                  state <= ST_CODE;
            end
            ST_FLAGS: if (f_ack) begin
               flag_ptr <= flag_ptr + ADDR_W'(FLAG_BYTES);
               state    <= ST_TOKEN;
            end
            ST_LIT: if (f_ack) begin
               hold     <= f_value[7:0];
               byte_ptr <= byte_ptr + 1'b1;
               state    <= ST_LITW;
            end
            ST_LITW: begin
               out_ptr <= out_ptr + 1'b1;
               state   <= ST_TOKEN;
            end
            ST_CODE: if (f_ack) begin
               code_ptr <= code_ptr + ADDR_W'(2);
               copy_src <= out_ptr - ADDR_W'(code_dist) - 1'b1;
               if (src_bad) begin
                  err_q <= 1'b1;
                  state <= ST_FIN;
               end else if (code_len != 4'd0) begin
                  copy_left <= RUN_W'(code_len) + RUN_W'(SHORT_BIAS);
                  state     <= ST_CRD;
               end else begin
                  state <= ST_EXT;
               end
            end
            ST_EXT: if (f_ack) begin
               copy_left <= RUN_W'(f_value[7:0]) + RUN_W'(LONG_BIAS);
               byte_ptr  <= byte_ptr + 1'b1;
               state     <= ST_CRD;
            end
            ST_CRD: if (f_ack) begin
               hold     <= f_value[7:0];
               copy_src <= copy_src + 1'b1;
               state    <= ST_CWR;
            end
            ST_CWR: begin
               out_ptr   <= out_ptr + 1'b1;
               copy_left <= copy_left - 1'b1;
               state     <= (copy_left == RUN_W'(1)) ? ST_TOKEN : ST_CRD;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy    = (state != ST_IDLE);
   assign done    = (state == ST_FIN);
   assign err     = err_q;
   assign wr_en   = (state == ST_LITW) || (state == ST_CWR);
   assign wr_addr = out_ptr;
   assign wr_data = hold;

   AST_NO_RW_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_en && wr_en)); // R11

   AST_WR_ABOVE_BASE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (wr_addr >= dst_q)); // R11

   AST_COPY_BEHIND: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_CRD && rd_en) |-> (rd_addr < out_ptr)); // R8

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy)); // R9

   AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy); // R2

   AST_ERR_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> done); // R10

endmodule

// File: tb/test_lz3_unpacker.sv
module test_lz3_unpacker;

   localparam int AW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [AW-1:0] src_base = '0;
   logic [AW-1:0] dst_base = '0;
   logic          busy, done, err, rd_en, wr_en;
   logic [AW-1:0] rd_addr, wr_addr;
   logic [7:0]    rd_data, wr_data;

   always #10 clk = ~clk;

   lz3_unpacker #(.ADDR_W(AW), .FLAG_W(32)) i_lz3_unpacker (
      .clk(clk), .rst_n(rst_n), .start(start),
      .src_base(src_base), .dst_base(dst_base),
      .busy(busy), .done(done), .err(err),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
   );

   logic [7:0] mem [0:4095];
   always @(posedge clk) begin
      if (wr_en) mem[wr_addr[11:0]] <= wr_data;
      if (rd_en) rd_data <= mem[rd_addr[11:0]];
   end

   int total = 0;
   int bad   = 0;

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // token list and reference output
   int t_lit [0:63];
   int t_val [0:63];
   int t_len [0:63];
   int t_dst [0:63];
   int ntok;
   int exp_out [0:2047];
   int exp_len;

   // write monitor
   int mon_writes, mon_out_range, mon_clash;
   int lo_lim, hi_lim;
   always @(negedge clk) begin
      if (rst_n) begin
         if (wr_en) begin
            mon_writes++;
            if (int'(wr_addr) < lo_lim || int'(wr_addr) >= hi_lim) mon_out_range++;
         end
         if (rd_en && wr_en) mon_clash++;
      end
   end

   task automatic put32(input int a, input int v);
      mem[a]     = v[31:24];
      mem[a + 1] = v[23:16];
      mem[a + 2] = v[15:8];
      mem[a + 3] = v[7:0];
   endtask

   // Pack the token list at base; the reference output is built separately.
   task automatic encode(input int base, input int coff, input int boff, input int hlen);
      int cp, bp, fw, code, L;
      cp = 0; bp = 0;
      for (int w = 0; w < 4; w++) put32(base + 16 + 4 * w, 0);
      for (int i = 0; i < ntok; i++) begin
         if (t_lit[i] != 0) begin
            fw = base + 16 + 4 * (i / 32);
            mem[fw + (i % 32) / 8] = mem[fw + (i % 32) / 8] | (8'h80 >> ((i % 32) % 8));
            mem[base + boff + bp] = t_val[i][7:0];
            bp++;
         end else begin
            if (t_len[i] >= 18) begin
               L = 0;
               mem[base + boff + bp] = 8'(t_len[i] - 18);
               bp++;
            end else L = t_len[i] - 2;
            code = (L << 12) | t_dst[i];
            mem[base + coff + cp]     = code[15:8];
            mem[base + coff + cp + 1] = code[7:0];
            cp += 2;
         end
      end
      put32(base + 4, hlen);
      put32(base + 8, coff);
      put32(base + 12, boff);
   endtask

   // Reference expansion from the requirement text (R5..R8).
   task automatic reference(output int produced);
      int n;
      n = 0;
      for (int i = 0; i < ntok; i++) begin
         if (t_lit[i] != 0) begin
            exp_out[n] = t_val[i]; n++;
         end else begin
            for (int k = 0; k < t_len[i]; k++) begin
               exp_out[n] = exp_out[n - t_dst[i] - 1]; n++;
            end
         end
      end
      produced = n;
   endtask

   task automatic run(input string tag, input int base, input int dst,
                      input int exp_err, input int exp_writes, input int lim_len);
      int cyc;
      int seen;
      int mism;
      for (int a = 2048; a < 4096; a++) mem[a] = 8'hEE;
      mon_writes = 0; mon_out_range = 0; mon_clash = 0;
      lo_lim = dst; hi_lim = dst + lim_len;
      @(negedge clk);
      src_base = AW'(base); dst_base = AW'(dst); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk({tag, " R2 busy after start"}, int'(busy), 1);
      repeat (3) @(negedge clk);
      src_base = AW'(base + 32); dst_base = AW'(dst + 5);
      start = busy;                      // R2: ignored while busy
      @(negedge clk);
      start = 1'b0;
      cyc = 0; seen = 0;
      while (cyc < 30000 && seen == 0) begin
         if (done) seen = 1;
         else begin @(negedge clk); cyc++; end
      end
      chk({tag, " R9 done reached"}, seen, 1);
      chk({tag, " R10 err flag"}, int'(err), exp_err);
      @(negedge clk);
      chk({tag, " R9 single done pulse"}, int'(done), 0);
      chk({tag, " R9 busy falls"}, int'(busy), 0);
      chk({tag, " R9 write count"}, mon_writes, exp_writes);
      chk({tag, " R11 writes in range"}, mon_out_range, 0);
      chk({tag, " R11 no read/write clash"}, mon_clash, 0);
      mism = 0;
      for (int i = 0; i < exp_writes; i++)
         if (int'(mem[dst + i]) != exp_out[i]) begin
            if (mism == 0)
               $display("FAIL %s R5-data byte %0d: actual=%0d expected=%0d",
                        tag, i, mem[dst + i], exp_out[i]);
            mism++;
         end
      total++;
      if (mism != 0) bad++;
      chk({tag, " R9 guard byte untouched"}, int'(mem[dst + exp_writes]), 8'hEE);
   endtask

   logic [31:0] lfsr = 32'h1ACE_B00C;
   function automatic int rnd();
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      return int'(lfsr[15:0]);
   endfunction

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      int n;
      for (int a = 0; a < 4096; a++) mem[a] = 8'h00;
      repeat (3) @(negedge clk);
      // R1
      chk("R1 busy in reset", int'(busy), 0);
      chk("R1 done in reset", int'(done), 0);
      chk("R1 err in reset", int'(err), 0);
      chk("R1 rd_en in reset", int'(rd_en), 0);
      chk("R1 wr_en in reset", int'(wr_en), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 idle after reset", int'(busy | wr_en | rd_en), 0);

      // R5 R4: 40 literals, crosses a control word boundary
      ntok = 40;
      for (int i = 0; i < ntok; i++) begin t_lit[i] = 1; t_val[i] = (i * 37 + 5) & 255; end
      reference(n);
      encode(16'h0000, 16'h0100, 16'h0200, n);
      run("lit40 R4 R5", 0, 2048, 0, n, n);

      // R6 R7 R8 R3: short, overlapping and long copies, distinct offsets
      ntok = 7;
      t_lit[0] = 1; t_val[0] = 65;
      t_lit[1] = 1; t_val[1] = 66;
      t_lit[2] = 1; t_val[2] = 67;
      t_lit[3] = 0; t_len[3] = 3;  t_dst[3] = 2;
      t_lit[4] = 0; t_len[4] = 5;  t_dst[4] = 0;
      t_lit[5] = 0; t_len[5] = 20; t_dst[5] = 1;
      t_lit[6] = 0; t_len[6] = 273; t_dst[6] = 6;
      reference(n);
      encode(16'h0240, 16'h0060, 16'h00A0, n);
      run("copies R3 R6 R7 R8", 16'h0240, 2100, 0, n, n);

      // R9: zero length writes nothing
      ntok = 1; t_lit[0] = 1; t_val[0] = 9;
      encode(16'h0400, 16'h0100, 16'h0180, 0);
      run("len0 R9", 16'h0400, 2048, 0, 0, 0);

      // R9: length shorter than the packed items stops early
      ntok = 4;
      for (int i = 0; i < 4; i++) begin t_lit[i] = 1; t_val[i] = 100 + i; end
      reference(n);
      encode(16'h0400, 16'h0100, 16'h0180, 2);
      run("short R9", 16'h0400, 2300, 0, 2, 2);

      // R10: copy source before dst_base
      ntok = 2;
      t_lit[0] = 1; t_val[0] = 65;
      t_lit[1] = 0; t_len[1] = 3; t_dst[1] = 5;
      exp_out[0] = 65;
      encode(16'h0500, 16'h0080, 16'h00C0, 10);
      run("bad ref R10", 16'h0500, 2200, 1, 1, 10);

      // sweep over generated streams
      for (int s = 1; s <= 6; s++) begin
         int prod;
         ntok = 40; prod = 0;
         for (int i = 0; i < ntok; i++) begin
            if (prod == 0 || (rnd() % 3) == 0) begin
               t_lit[i] = 1; t_val[i] = rnd() & 255; prod++;
            end else begin
               t_lit[i] = 0;
               t_dst[i] = rnd() % ((prod < 4095) ? prod : 4095);
               t_len[i] = ((rnd() % 4) == 0) ? 18 + rnd() % 30 : 3 + rnd() % 15;
               prod += t_len[i];
            end
         end
         reference(n);
         encode(s * 64, 16'h0200, 16'h0300, n);
         run($sformatf("sweep%0d R4 R6 R7 R8", s), s * 64, 2048 + s, 0, n, n);
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule